// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block is a set of hardware event counters for a system-on-chip. A 64-bit cycle counter starts when reset is released and counts every platform clock with no setup. Software cannot stop, freeze or load it. Nine general 32-bit counters, numbered 1 to 9, each count one event. A 7-bit code in the counter's control word picks the event. Each event arrives as a single-cycle pulse.

The code has two classes, chosen by its top bit. With bit 6 clear, the low six bits pick one of the shared reference events. Every counter sees the same set of reference events. With bit 6 set, the low six bits pick one of the private events wired to that counter alone. Private codes are therefore the local event number plus 64. A code that names no existing event counts nothing.

Software uses a simple word-addressed register port to set up the counters, preload counts, read values back and clear overflow flags. The cycle counter is read as two halves, and reading the low half captures the high half so that the pair is coherent. Each general counter drives a sticky level flag that sets when the counter rolls over.

Top module: `perf_counter_bank`

## Requirements
- R1: The 64-bit cycle counter is zero while reset is held. It then adds one on every clock edge after release. Writes to its addresses have no effect on it.
- R2: A read of address 0x01 returns cycle-count bits 31:0. The same read captures bits 63:32, which address 0x02 then returns until the next low read.
- R3: Counter n (1 to 9) has a control word at address 0x10+n and a count at address 0x20+n. The control word holds the event code in bits 6:0 and the enable in bit 8, and it reads back as written.
- R4: A code with bit 6 clear selects reference event bits 5:0 (0 to 15). Every counter that selects the same reference code sees the same input.
- R5: A code with bit 6 set selects private event bits 5:0 (0 to 3) of that counter. Counter n's private inputs are priv_evt[4(n-1)+3 : 4(n-1)]. Private inputs of other counters are never counted.
- R6: A code that names no existing event (reference index 16 or above, or private index 4 or above) counts nothing.
- R7: While the counter is enabled and not frozen, each clock with the selected event high adds exactly one to the count at that edge.
- R8: With the enable bit clear, or with the freeze bit (bit 0 of address 0x00) set, a counter holds its value.
- R9: A write to a count address loads the written value. When the write and an event fall in the same cycle, the written value is kept and the event is lost.
- R10: A step from 0xFFFFFFFF to 0 sets that counter's sticky overflow flag, seen on ovf_flag[n-1] and at bit n-1 of address 0x03. Writing one to the bit clears the flag, and writing zero leaves it set. A rollover in the same cycle as a clear leaves the flag set.
- R11: After reset every count, control word, the freeze bit and every overflow flag read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Platform clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (used for the cycle-count snapshot) |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| ref_evt | input | 16 | Shared reference event pulses |
| priv_evt | input | 36 | Private event pulses, four per general counter |
| ovf_flag | output | 9 | Sticky overflow flag per general counter |
| ovf_any | output | 1 | OR of all overflow flags |

## Verification
The assertions assume that only one register write happens per cycle and that read and write strobes are never X. They also assume the event inputs are sampled only at clock edges, so a pulse held for k cycles counts as k events. The stimulus changes every input on the falling edge and holds it for whole cycles. It drives the write strobe for a single cycle per access. It drops event lines on the same falling edge as a colliding write, so no extra event leaks in after the preload.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int NUM_GEN  = 9;
  localparam int GEN_W    = 32;
  localparam int CYC_W    = 64;
  localparam int CODE_W   = 7;
  localparam int NUM_REF  = 16;
  localparam int NUM_PRIV = 4;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 32;
  localparam int EN_POS   = 8;

  localparam logic [ADDR_W-1:0] A_GCTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_CYC_LO = 6'h01;
  localparam logic [ADDR_W-1:0] A_CYC_HI = 6'h02;
  localparam logic [ADDR_W-1:0] A_OVF    = 6'h03;
  localparam logic [1:0]        PG_CTRL  = 2'b01;
  localparam logic [1:0]        PG_CNT   = 2'b10;
endpackage

// File: rtl/perf_event_sel.sv
module perf_event_sel #(
  parameter int CODE_W   = 7,
  parameter int NUM_REF  = 16,
  parameter int NUM_PRIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   code,
  input  logic [NUM_REF-1:0]  ref_evt,
  input  logic [NUM_PRIV-1:0] priv_evt,
  output logic                evt
);
  localparam int IDX_W = CODE_W - 1;

  logic             priv_cls;
  logic [IDX_W-1:0] idx;
  logic             ref_hit;
  logic             priv_hit;

  assign priv_cls = code[CODE_W-1];
  assign idx      = code[IDX_W-1:0];

  always_comb begin
    ref_hit = 1'b0;
    for (int i = 0; i < NUM_REF; i++) begin
      if (idx == IDX_W'(i)) ref_hit = ref_evt[i];
    end
  end

  always_comb begin
    priv_hit = 1'b0;
    for (int i = 0; i < NUM_PRIV; i++) begin
      if (idx == IDX_W'(i)) priv_hit = priv_evt[i];
    end
  end

  assign evt = priv_cls ? priv_hit : ref_hit;

  // R5: a private code never sees reference traffic
  a_r5_priv_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_cls && priv_evt == '0) |-> !evt);
  // R4: a reference code never sees private traffic
  a_r4_ref_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_cls && ref_evt == '0) |-> !evt);
  // R6: unused private index
  a_r6_priv_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_cls && {1'b0, idx} >= (IDX_W+1)'(NUM_PRIV)) |-> !evt);
  // R6: unused reference index
  a_r6_ref_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_cls && {1'b0, idx} >= (IDX_W+1)'(NUM_REF)) |-> !evt);
endmodule

// File: rtl/perf_gen_counter.sv
module perf_gen_counter #(
  parameter int CNT_W    = 32,
  parameter int CODE_W   = 7,
  parameter int NUM_REF  = 16,
  parameter int NUM_PRIV = 4,
  parameter int EN_POS   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                freeze,
  input  logic                ctrl_we,
  input  logic                cnt_we,
  input  logic                ovf_clr,
  input  logic [CNT_W-1:0]    wdata,
  input  logic [NUM_REF-1:0]  ref_evt,
  input  logic [NUM_PRIV-1:0] priv_evt,
  output logic [CODE_W-1:0]   code,
  output logic                en,
  output logic [CNT_W-1:0]    cnt,
  output logic                ovf
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              en_q, en_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              evt;
  logic              step;
  logic              wrap;
  logic              cnt_ce;

  perf_event_sel #(
    .CODE_W  (CODE_W),
    .NUM_REF (NUM_REF),
    .NUM_PRIV(NUM_PRIV)
  ) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (code_q),
    .ref_evt (ref_evt),
    .priv_evt(priv_evt),
    .evt     (evt)
  );

  assign step   = evt & en_q & ~freeze;
  assign wrap   = step & ~cnt_we & (cnt_q == {CNT_W{1'b1}});
  assign cnt_ce = cnt_we | step;

  always_comb begin
    code_d = ctrl_we ? wdata[CODE_W-1:0] : code_q;
    en_d   = ctrl_we ? wdata[EN_POS]     : en_q;
    cnt_d  = cnt_we  ? wdata             : cnt_q + 1'b1;
    ovf_d  = wrap | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      en_q   <= 1'b0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (ctrl_we) begin
        code_q <= code_d;
        en_q   <= en_d;
      end
      if (cnt_ce) cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign code = code_q;
  assign en   = en_q;
  assign cnt  = cnt_q;
  assign ovf  = ovf_q;

  // R7: one step per event cycle
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && evt && en && !freeze) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R8: disabled or frozen counter holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && (!en || freeze)) |=> $stable(cnt));
  // R9: preload wins
  a_r9_preload: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt == $past(wdata));
  // R10: sticky until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  // R10: rollover sets the flag
  a_r10_set_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && evt && en && !freeze && cnt == {CNT_W{1'b1}}) |=> (ovf && cnt == '0));
endmodule

// File: rtl/perf_cycle_counter.sv
module perf_cycle_counter #(
  parameter int CYC_W  = 64,
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lo_rd,
  output logic [HALF_W-1:0]     lo,
  output logic [CYC_W-HALF_W-1:0] hi_snap
);
  localparam int UP_W = CYC_W - HALF_W;

  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [UP_W-1:0]  hi_q, hi_d;

  always_comb begin
    cyc_d = cyc_q + 1'b1;
    hi_d  = cyc_q[CYC_W-1:HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      hi_q  <= '0;
    end else begin
      cyc_q <= cyc_d;
      if (lo_rd) hi_q <= hi_d;
    end
  end

  assign lo      = cyc_q[HALF_W-1:0];
  assign hi_snap = hi_q;

  // R1: free-running
  a_r1_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cyc_q == CYC_W'($past(cyc_q) + 1'b1));
  // R2: snapshot taken on a low read
  a_r2_snap_take: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> hi_q == $past(cyc_q[CYC_W-1:HALF_W]));
  // R2: snapshot held otherwise
  a_r2_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_rd |=> $stable(hi_q));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perfmon_pkg::*;
#(
  parameter int N_GEN  = NUM_GEN,
  parameter int N_REF  = NUM_REF,
  parameter int N_PRIV = NUM_PRIV
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic                    reg_re,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic [N_REF-1:0]        ref_evt,
  input  logic [N_GEN*N_PRIV-1:0] priv_evt,
  output logic [N_GEN-1:0]        ovf_flag,
  output logic                    ovf_any
);
  localparam int SLOT_W = 4;
  localparam int UP_W   = CYC_W - DATA_W;

  logic [1:0]        page;
  logic [SLOT_W-1:0] slot;
  logic              freeze_q, freeze_d, freeze_we;
  logic              lo_rd;
  logic [DATA_W-1:0] cyc_lo;
  logic [UP_W-1:0]   cyc_hi;

  logic [N_GEN-1:0]              ctrl_we;
  logic [N_GEN-1:0]              cnt_we;
  logic [N_GEN-1:0]              ovf_clr;
  logic [N_GEN-1:0]              en_v;
  logic [N_GEN-1:0][CODE_W-1:0]  code_v;
  logic [N_GEN-1:0][GEN_W-1:0]   cnt_v;

  assign page      = reg_addr[ADDR_W-1:SLOT_W];
  assign slot      = reg_addr[SLOT_W-1:0];
  assign lo_rd     = reg_re && (reg_addr == A_CYC_LO);
  assign freeze_we = reg_we && (reg_addr == A_GCTRL);
  assign freeze_d  = reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) freeze_q <= 1'b0;
    else if (freeze_we) freeze_q <= freeze_d;
  end

  perf_cycle_counter #(
    .CYC_W (CYC_W),
    .HALF_W(DATA_W)
  ) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .lo_rd  (lo_rd),
    .lo     (cyc_lo),
    .hi_snap(cyc_hi)
  );

  for (genvar g = 0; g < N_GEN; g++) begin : g_ctr
    assign ctrl_we[g] = reg_we && (page == PG_CTRL) && (slot == SLOT_W'(g + 1));
    assign cnt_we[g]  = reg_we && (page == PG_CNT)  && (slot == SLOT_W'(g + 1));
    assign ovf_clr[g] = reg_we && (reg_addr == A_OVF) && reg_wdata[g];

    perf_gen_counter #(
      .CNT_W   (GEN_W),
      .CODE_W  (CODE_W),
      .NUM_REF (N_REF),
      .NUM_PRIV(N_PRIV),
      .EN_POS  (EN_POS)
    ) u_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .freeze  (freeze_q),
      .ctrl_we (ctrl_we[g]),
      .cnt_we  (cnt_we[g]),
      .ovf_clr (ovf_clr[g]),
      .wdata   (reg_wdata),
      .ref_evt (ref_evt),
      .priv_evt(priv_evt[g*N_PRIV +: N_PRIV]),
      .code    (code_v[g]),
      .en      (en_v[g]),
      .cnt     (cnt_v[g]),
      .ovf     (ovf_flag[g])
    );
  end

  assign ovf_any = |ovf_flag;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_GCTRL:  reg_rdata = DATA_W'(freeze_q);
      A_CYC_LO: reg_rdata = cyc_lo;
      A_CYC_HI: reg_rdata = DATA_W'(cyc_hi);
      A_OVF:    reg_rdata = DATA_W'(ovf_flag);
      default: begin
        for (int i = 0; i < N_GEN; i++) begin
          if (slot == SLOT_W'(i + 1)) begin
            if (page == PG_CTRL)
              reg_rdata = DATA_W'({en_v[i], 1'b0, code_v[i]});
            else if (page == PG_CNT)
              reg_rdata = cnt_v[i];
          end
        end
      end
    endcase
  end

  // R3: a write strobe reaches at most one register of the bank
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, cnt_we, freeze_we}));
  // R10: a clear request drops a flag that no rollover re-sets
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr[0] && !cnt_we[0] && !en_v[0]) |=> !ovf_flag[0]);
endmodule

// File: tb/perf_counter_bank_tb.sv
`timescale 1ns/1ps
module perf_counter_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_re;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] ref_evt;
  logic [35:0] priv_evt;
  logic [8:0]  ovf_flag;
  logic        ovf_any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] bc;

  always #2.5 clk = ~clk;

  perf_counter_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ref_evt(ref_evt), .priv_evt(priv_evt), .ovf_flag(ovf_flag), .ovf_any(ovf_any)
  );

  // independent model of the cycle count (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bc <= '0;
    else bc <= bc + 64'd1;
  end

  // {ctr[4], code[8], ref[16], priv[36], cycles[8], expected[8]}
  localparam int NV = 10;
  localparam logic [79:0] VEC [NV] = '{
    {4'd1, 8'h03, 16'hFFFF, 36'h0,         8'd5, 8'd5}, // R4 ref 3 on counter 1
    {4'd5, 8'h03, 16'hFFFF, 36'h0,         8'd5, 8'd5}, // R4 same ref on counter 5
    {4'd7, 8'h0F, 16'h8000, 36'h0,         8'd4, 8'd4}, // R4 top ref index
    {4'd6, 8'h02, 16'hFFFB, 36'hF_FFFF_FFFF, 8'd6, 8'd0}, // R4 other lines quiet
    {4'd2, 8'h41, 16'hFFFF, 36'h0_0000_0020, 8'd7, 8'd7}, // R5 counter 2 private 1
    {4'd3, 8'h41, 16'hFFFF, 36'h0_0000_0020, 8'd7, 8'd0}, // R5 counter 2 lines unseen by 3
    {4'd3, 8'h43, 16'h0,    36'h0_0000_0800, 8'd3, 8'd3}, // R5 counter 3 private 3
    {4'd9, 8'h40, 16'h0,    36'h1_0000_0000, 8'd6, 8'd6}, // R5 counter 9 private 0
    {4'd9, 8'h45, 16'hFFFF, 36'hF_FFFF_FFFF, 8'd6, 8'd0}, // R6 private index 5
    {4'd4, 8'h20, 16'hFFFF, 36'hF_FFFF_FFFF, 8'd6, 8'd0}  // R6 reference index 32
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] snap;
    rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0; reg_wdata = '0;
    ref_evt = '0; priv_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    for (int n = 1; n <= 9; n++) begin
      rd(6'h20 + 6'(n), d); chk("R11 count after reset", d, 0);
      rd(6'h10 + 6'(n), d); chk("R11 control after reset", d, 0);
    end
    rd(6'h00, d); chk("R11 freeze after reset", d, 0);
    chk("R11 overflow flags after reset", ovf_flag, 0);

    // R1/R2 cycle counter
    reg_addr = 6'h01; reg_re = 1'b1;
    #1 d = reg_rdata; snap = bc;
    chk("R1 cycle low", d, snap[31:0]);
    @(negedge clk); reg_re = 1'b0;
    repeat (4) @(negedge clk);
    rd(6'h02, d); chk("R2 cycle high snapshot", d, snap[63:32]);
    wr(6'h01, 32'h0); wr(6'h02, 32'hFFFF_FFFF);
    reg_addr = 6'h01; reg_re = 1'b1;
    #1 d = reg_rdata; snap = bc;
    chk("R1 cycle low unaffected by writes", d, snap[31:0]);
    @(negedge clk); reg_re = 1'b0;

    // table-driven event selection (R4 R5 R6 R7)
    for (int v = 0; v < NV; v++) begin
      logic [3:0]  ctr;
      logic [7:0]  code, cyc, exp;
      logic [15:0] rv;
      logic [35:0] pv;
      {ctr, code, rv, pv, cyc, exp} = VEC[v];
      wr(6'h10 + 6'(ctr), 32'h100 | 32'(code));
      rd(6'h10 + 6'(ctr), d);
      chk("R3 control readback", d, 32'h100 | 32'(code));
      wr(6'h20 + 6'(ctr), 32'h0);
      ref_evt = rv; priv_evt = pv;
      repeat (int'(cyc)) @(negedge clk);
      ref_evt = '0; priv_evt = '0;
      rd(6'h20 + 6'(ctr), d);
      chk("R7 count after event cycles (R4 R5 R6)", d, 32'(exp));
    end

    // R8 freeze and enable
    wr(6'h11, 32'h100);
    wr(6'h21, 32'd5);
    wr(6'h00, 32'h1);
    ref_evt = 16'h0001; repeat (4) @(negedge clk); ref_evt = '0;
    rd(6'h21, d); chk("R8 frozen counter holds", d, 5);
    wr(6'h00, 32'h0);
    wr(6'h11, 32'h000);
    ref_evt = 16'h0001; repeat (4) @(negedge clk); ref_evt = '0;
    rd(6'h21, d); chk("R8 disabled counter holds", d, 5);
    wr(6'h11, 32'h100);
    ref_evt = 16'h0001; @(negedge clk); ref_evt = '0;
    rd(6'h21, d); chk("R7 single pulse adds one", d, 6);

    // R9 write beats a same-cycle event
    ref_evt = 16'h0001;
    wr(6'h21, 32'h0000_1234);
    ref_evt = '0;
    rd(6'h21, d); chk("R9 preload wins over event", d, 32'h1234);

    // R10 overflow
    wr(6'h21, 32'hFFFF_FFFE);
    ref_evt = 16'h0001; repeat (2) @(negedge clk); ref_evt = '0;
    rd(6'h21, d); chk("R10 count wrapped", d, 0);
    chk("R10 flag set", ovf_flag, 9'h001);
    chk("R10 any flag", ovf_any, 1);
    rd(6'h03, d); chk("R10 status register", d, 1);
    wr(6'h03, 32'h0);
    chk("R10 write zero keeps flag", ovf_flag, 9'h001);
    wr(6'h03, 32'h1);
    chk("R10 write one clears flag", ovf_flag, 9'h000);
    wr(6'h21, 32'hFFFF_FFFF);
    ref_evt = 16'h0001;
    wr(6'h03, 32'h1);
    ref_evt = '0;
    chk("R10 rollover beats clear", ovf_flag, 9'h001);
    wr(6'h03, 32'h1FF);
    chk("R10 flags cleared", ovf_any, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule